// File: doc/BRIEF.md
# Twinax Receive Message Controller

This block sits behind a frame decoder on the receive side of a 16-bit framed twinax-style link. For each decoded frame the decoder hands over the 3-bit station address, an error indication and a valid strobe. The controller decides which frames go on to the receive FIFO and signals when a message starts and ends. In non-promiscuous mode it filters on the station address of the first frame only. Once that frame is accepted, every later frame of the same message goes through unfiltered.

The controller also has to tell a real end of message from a loss of synchronization. When the decoder reports that sync was lost while fill bits were arriving, the controller opens a window counted in bit-time ticks. If line activity stops inside the window, the message ended normally: the receiver goes idle and raises the line turn-around pulse. If the line is still busy when the window runs out, the controller raises the sync-loss error pulse instead. A frame passed with station address 111 is flagged as the end-of-message marker.

Top module: `rxmsg_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rxActive, passStrobe, endOfMsg, turnAround and syncErr are all low.
- R2: A startDet pulse while idle sets rxActive high from the next cycle on.
- R3: In promiscuous mode (promisc=1), every frame of an active message produces a one-cycle passStrobe in the cycle after frameValid, whatever its address.
- R4: In non-promiscuous mode, a first frame whose address equals stationAddr is passed, and every later frame of that message is passed whatever its address.
- R5: In non-promiscuous mode, a first frame with a different address and frameErr low produces no passStrobe. rxActive drops in the next cycle, and later frames are ignored until the next startDet.
- R6: A mismatched first frame that has frameErr high is still passed, and the rest of its message is passed as well.
- R7: endOfMsg is high exactly in those passStrobe cycles whose frame carried address 3'b111.
- R8: After syncLoss, if lineActive is sampled low before the window expires, the controller pulses turnAround for one cycle in the next cycle and rxActive falls at the same time.
- R9: After syncLoss, if lineActive stays high through WIN_TICKS (default 11) bitTick pulses, syncErr pulses for one cycle after the last tick, rxActive falls, and turnAround stays low.
- R10: In non-promiscuous mode, a message whose first frame did not match the address never produces turnAround, although it still returns to idle when the line drops.
- R11: Each syncLoss pulse during the window restarts the tick count from zero.
- R12: When lineActive is low in the same cycle as the window's final tick, the outcome is turnAround, and syncErr stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| promisc | input | 1 | 1 = pass all frames, 0 = filter on the first frame |
| stationAddr | input | 3 | Local station address used by the filter |
| startDet | input | 1 | Valid start sequence seen |
| frameValid | input | 1 | Decoded frame strobe |
| frameAddr | input | 3 | Station address field of the decoded frame |
| frameErr | input | 1 | Decoded frame carries an error |
| syncLoss | input | 1 | Sync lost during fill bits |
| lineActive | input | 1 | Line activity detected |
| bitTick | input | 1 | One pulse per bit time |
| rxActive | output | 1 | Receiver busy with a message |
| passStrobe | output | 1 | Frame forwarded to the FIFO |
| endOfMsg | output | 1 | Forwarded frame carries address 111 |
| turnAround | output | 1 | Normal message end pulse |
| syncErr | output | 1 | Sync-loss error pulse |

## Verification
Two events can land in the same cycle: the line-drop that ends a message and the final bit tick that would expire the window. The bench provokes this by sending ten ticks with the line busy. It then lowers lineActive in the same cycle as it raises the eleventh tick. The scoreboard expects a turnAround pulse and no syncErr in the next cycle. A separate run with a second syncLoss in the middle of the window checks that the count really restarts.

// File: rtl/rxmsg_pkg.sv
package rxmsg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_PASS  = 2'd2,
    ST_WATCH = 2'd3
  } rxState_e;

  typedef struct packed {
    logic passFrame;
    logic setMatch;
    logic clrMatch;
    logic winRestart;
    logic winStep;
    logic raiseLta;
    logic raiseErr;
  } ctlStb_t;
endpackage

// File: rtl/rxmsg_ctl.sv
module rxmsg_ctl
  import rxmsg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    promisc,
  input  logic    startDet,
  input  logic    frameValid,
  input  logic    frameErr,
  input  logic    syncLoss,
  input  logic    lineActive,
  input  logic    bitTick,
  input  logic    addrHit,
  input  logic    winLast,
  input  logic    matched,
  output ctlStb_t stb,
  output logic    rxActive
);
  rxState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (startDet) begin
          nextState    = ST_FIRST;
          stb.clrMatch = 1'b1;
        end
      end
      ST_FIRST: begin
        if (frameValid) begin
          if (promisc || addrHit) begin
            stb.passFrame = 1'b1;
            stb.setMatch  = 1'b1;
            nextState     = ST_PASS;
          end else if (frameErr) begin
            stb.passFrame = 1'b1;
            nextState     = ST_PASS;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      ST_PASS: begin
        if (frameValid) begin
          stb.passFrame = 1'b1;
        end else if (syncLoss) begin
          stb.winRestart = 1'b1;
          nextState      = ST_WATCH;
        end
      end
      ST_WATCH: begin
        if (!lineActive) begin
          stb.raiseLta = matched;
          nextState    = ST_IDLE;
        end else if (syncLoss) begin
          stb.winRestart = 1'b1;
        end else if (bitTick) begin
          if (winLast) begin
            stb.raiseErr = 1'b1;
            nextState    = ST_IDLE;
          end else begin
            stb.winStep = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign rxActive = (state != ST_IDLE);
endmodule

// File: rtl/rxmsg_dp.sv
module rxmsg_dp
  import rxmsg_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int WIN_TICKS = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           stb,
  input  logic [ADDR_W-1:0] frameAddr,
  input  logic [ADDR_W-1:0] stationAddr,
  output logic              addrHit,
  output logic              winLast,
  output logic              matched,
  output logic              passStrobe,
  output logic              endOfMsg,
  output logic              turnAround,
  output logic              syncErr
);
  localparam int CNT_W = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIN_TICKS - 1);
  localparam logic [ADDR_W-1:0] EOM_ADDR = '1;

  logic [CNT_W-1:0] winCnt;

  assign addrHit = (frameAddr == stationAddr);
  assign winLast = (winCnt == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (stb.winRestart) begin
      winCnt <= '0;
    end else if (stb.winStep) begin
      winCnt <= winCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             matched <= 1'b0;
    else if (stb.clrMatch) matched <= 1'b0;
    else if (stb.setMatch) matched <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      passStrobe <= 1'b0;
      endOfMsg   <= 1'b0;
      turnAround <= 1'b0;
      syncErr    <= 1'b0;
    end else begin
      passStrobe <= stb.passFrame;
      endOfMsg   <= stb.passFrame && (frameAddr == EOM_ADDR);
      turnAround <= stb.raiseLta;
      syncErr    <= stb.raiseErr;
    end
  end
endmodule

// File: rtl/rxmsg_top.sv
module rxmsg_top
  import rxmsg_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int WIN_TICKS = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              promisc,
  input  logic [ADDR_W-1:0] stationAddr,
  input  logic              startDet,
  input  logic              frameValid,
  input  logic [ADDR_W-1:0] frameAddr,
  input  logic              frameErr,
  input  logic              syncLoss,
  input  logic              lineActive,
  input  logic              bitTick,
  output logic              rxActive,
  output logic              passStrobe,
  output logic              endOfMsg,
  output logic              turnAround,
  output logic              syncErr
);
  ctlStb_t stb;
  logic    addrHit, winLast, matched;

  rxmsg_ctl u_ctl (
    .clk(clk), .rstN(rstN), .promisc(promisc), .startDet(startDet),
    .frameValid(frameValid), .frameErr(frameErr), .syncLoss(syncLoss),
    .lineActive(lineActive), .bitTick(bitTick), .addrHit(addrHit),
    .winLast(winLast), .matched(matched), .stb(stb), .rxActive(rxActive)
  );

  rxmsg_dp #(.ADDR_W(ADDR_W), .WIN_TICKS(WIN_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .frameAddr(frameAddr),
    .stationAddr(stationAddr), .addrHit(addrHit), .winLast(winLast),
    .matched(matched), .passStrobe(passStrobe), .endOfMsg(endOfMsg),
    .turnAround(turnAround), .syncErr(syncErr)
  );
endmodule

// File: rtl/rxmsg_chk.sv
module rxmsg_chk (
  input logic clk,
  input logic rstN,
  input logic rxActive,
  input logic passStrobe,
  input logic endOfMsg,
  input logic turnAround,
  input logic syncErr
);
  AST_PASS_IN_MSG: assert property (@(posedge clk) disable iff (!rstN)
    passStrobe |-> $past(rxActive)); // R3
  AST_EOM_ON_PASS: assert property (@(posedge clk) disable iff (!rstN)
    endOfMsg |-> passStrobe); // R7
  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(turnAround && syncErr)); // R12
  AST_LTA_GOES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    turnAround |-> (!rxActive && $past(rxActive))); // R8
  AST_ERR_GOES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    syncErr |-> (!rxActive && $past(rxActive))); // R9
  AST_LTA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    turnAround |=> !turnAround); // R8
endmodule

bind rxmsg_top rxmsg_chk u_chk (
  .clk(clk), .rstN(rstN), .rxActive(rxActive), .passStrobe(passStrobe),
  .endOfMsg(endOfMsg), .turnAround(turnAround), .syncErr(syncErr)
);

// File: tb/rxmsg_top_bench.sv
module rxmsg_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic promisc = 1'b0;
  logic [2:0] stationAddr = 3'd3;
  logic startDet = 1'b0, frameValid = 1'b0, frameErr = 1'b0;
  logic [2:0] frameAddr = 3'd0;
  logic syncLoss = 1'b0, lineActive = 1'b1, bitTick = 1'b0;
  logic rxActive, passStrobe, endOfMsg, turnAround, syncErr;

  int nRun = 0, nFail = 0, cyc = 0;
  bit done = 1'b0;
  int qAt[$];
  logic [3:0] qVal[$];
  string qTag[$];

  always #4 clk = ~clk;

  rxmsg_top u_rxmsg_top (
    .clk(clk), .rstN(rstN), .promisc(promisc), .stationAddr(stationAddr),
    .startDet(startDet), .frameValid(frameValid), .frameAddr(frameAddr),
    .frameErr(frameErr), .syncLoss(syncLoss), .lineActive(lineActive),
    .bitTick(bitTick), .rxActive(rxActive), .passStrobe(passStrobe),
    .endOfMsg(endOfMsg), .turnAround(turnAround), .syncErr(syncErr)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: {passStrobe, endOfMsg, turnAround, syncErr}
  always @(negedge clk) begin
    logic [3:0] obs;
    obs = {passStrobe, endOfMsg, turnAround, syncErr};
    if (rstN && !done) begin
      if (qAt.size() > 0 && qAt[0] == cyc) begin
        nRun++;
        if (obs !== qVal[0]) begin
          nFail++;
          $display("FAIL %s: pulses got %b expected %b", qTag[0], obs, qVal[0]);
        end
        void'(qAt.pop_front()); void'(qVal.pop_front()); void'(qTag.pop_front());
      end else if (obs !== 4'b0000) begin
        nRun++; nFail++;
        $display("FAIL R5/R10 unexpected pulse: got %b expected 0000", obs);
      end
    end
  end

  task automatic expect4(input logic [3:0] v, input string tag);
    qAt.push_back(cyc + 1); qVal.push_back(v); qTag.push_back(tag);
  endtask

  task automatic checkAct(input logic exp, input string tag);
    nRun++;
    if (rxActive !== exp) begin
      nFail++;
      $display("FAIL %s: rxActive got %b expected %b", tag, rxActive, exp);
    end
  endtask

  task automatic startMsg(input string tag);
    startDet = 1'b1; @(negedge clk); startDet = 1'b0;
    checkAct(1'b1, tag);
  endtask

  task automatic sendFrame(input logic [2:0] a, input logic e, input logic pass, input string tag);
    frameValid = 1'b1; frameAddr = a; frameErr = e;
    if (pass) expect4({1'b1, a == 3'b111, 2'b00}, tag);
    @(negedge clk);
    frameValid = 1'b0; frameErr = 1'b0;
  endtask

  task automatic loseSync();
    syncLoss = 1'b1; @(negedge clk); syncLoss = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bitTick = 1'b1; @(negedge clk); bitTick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic dropLine(input logic lta, input string tag);
    lineActive = 1'b0;
    if (lta) expect4(4'b0010, tag);
    @(negedge clk);
    lineActive = 1'b1;
    checkAct(1'b0, tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    nRun++;
    if ({rxActive, passStrobe, endOfMsg, turnAround, syncErr} !== 5'b0) begin
      nFail++;
      $display("FAIL R1: outputs got %b expected 00000",
               {rxActive, passStrobe, endOfMsg, turnAround, syncErr});
    end
    rstN = 1'b1;
    @(negedge clk);
    checkAct(1'b0, "R1");

    // promiscuous message, line drop ends it
    promisc = 1'b1;
    startMsg("R2");
    sendFrame(3'd2, 1'b0, 1'b1, "R3");
    sendFrame(3'd5, 1'b0, 1'b1, "R3");
    sendFrame(3'd7, 1'b0, 1'b1, "R7");
    loseSync();
    ticks(3);
    dropLine(1'b1, "R8");

    // non-promiscuous, first frame matches
    promisc = 1'b0;
    startMsg("R2");
    sendFrame(3'd3, 1'b0, 1'b1, "R4");
    sendFrame(3'd6, 1'b0, 1'b1, "R4");
    sendFrame(3'd7, 1'b0, 1'b1, "R7");
    loseSync();
    dropLine(1'b1, "R8");

    // mismatch without error is dropped
    startMsg("R2");
    sendFrame(3'd4, 1'b0, 1'b0, "R5");
    checkAct(1'b0, "R5");
    sendFrame(3'd3, 1'b0, 1'b0, "R5");
    checkAct(1'b0, "R5");

    // mismatch with error is passed, no turn-around
    startMsg("R2");
    sendFrame(3'd5, 1'b1, 1'b1, "R6");
    sendFrame(3'd2, 1'b0, 1'b1, "R6");
    loseSync();
    ticks(2);
    dropLine(1'b0, "R10");

    // window expiry
    promisc = 1'b1;
    startMsg("R2");
    sendFrame(3'd1, 1'b0, 1'b1, "R3");
    loseSync();
    ticks(10);
    checkAct(1'b1, "R9");
    bitTick = 1'b1; expect4(4'b0001, "R9"); @(negedge clk); bitTick = 1'b0;
    checkAct(1'b0, "R9");

    // restart of the window
    startMsg("R2");
    sendFrame(3'd0, 1'b0, 1'b1, "R3");
    loseSync();
    ticks(6);
    loseSync();
    ticks(10);
    checkAct(1'b1, "R11");
    bitTick = 1'b1; expect4(4'b0001, "R11"); @(negedge clk); bitTick = 1'b0;
    checkAct(1'b0, "R11");

    // line drop in the same cycle as the final tick
    startMsg("R2");
    sendFrame(3'd4, 1'b0, 1'b1, "R3");
    loseSync();
    ticks(10);
    bitTick = 1'b1; lineActive = 1'b0; expect4(4'b0010, "R12");
    @(negedge clk);
    bitTick = 1'b0; lineActive = 1'b1;
    checkAct(1'b0, "R12");

    repeat (4) @(negedge clk);
    if (qAt.size() != 0) begin
      nRun++; nFail++;
      $display("FAIL %s: pulses got none expected %b", qTag[0], qVal[0]);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule